// File: doc/BRIEF.md
# Overload Limit Detector with Windowed Glitch Filter

This block watches the raw, unscaled sample stream of a fast, low-decimation sinc filter that digitizes a motor winding current. Negative full scale arrives as 0 and positive full scale as D^O, where D is the decimation rate and O the filter order. Each accepted sample is compared against a programmable upper and lower limit. A sample that lies strictly outside the band counts as an overload.

A windowed glitch filter groups the accepted samples into consecutive windows of a programmable length. The block trips only when the number of overload samples inside one window reaches a programmable threshold. Short noise spikes are rejected, and a real overload is reported after roughly threshold-many samples. The trip output is meant to drive a PWM shutdown input directly. It stays high until it is cleared explicitly. A maskable interrupt flag rises together with it.

For diagnostics, the block keeps the eight most recent accepted samples, the tripping sample included. This history is frozen while a trip is pending. Opening the limits to full range (upper all ones, lower zero) keeps the detector quiet while the upstream filter fills after start-up.

Top module: `ovl_trip_detector`

## Requirements
- R1: After reset, `trip` and `irq_flag` are 0 and every history slot reads 0.
- R2: An accepted sample is an overload only when it is strictly greater than `lim_hi` or strictly less than `lim_lo`. A sample equal to either limit is not an overload.
- R3: Accepted samples are grouped into consecutive windows of `win_len` samples (0 acts as 1), counted from reset or the last clear. The overload count restarts at every window start, so overloads in different windows never add up. `trip` goes high on the clock edge that takes the overload sample bringing the count of its window to `need_cnt` (0 acts as 1).
- R4: Once high, `trip` stays high until `trip_clear`. Samples taken while it is high are ignored.
- R5: `trip_clear` drops `trip` and `irq_flag` on the next edge and restarts the window at its first position. A sample presented in the same cycle as `trip_clear` is ignored.
- R6: `hist_data` slot k (bits [16k+15:16k]) holds the k-th most recent accepted sample, with slot 0 the newest and the tripping sample included. The slots do not change while `trip` is high.
- R7: `irq_flag` rises with `trip` only if `irq_en` is 1 in the tripping cycle. It is cleared only by `trip_clear`.
- R8: A cycle with `smp_valid` low changes neither the count, the window position, the history nor the outputs.
- R9: With `lim_hi` all ones and `lim_lo` zero, no sample value can trip the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Secondary sample strobe |
| smp_data | input | 16 | Unsigned secondary sample |
| lim_hi | input | 16 | Upper limit |
| lim_lo | input | 16 | Lower limit |
| need_cnt | input | 8 | Overloads needed in one window to trip |
| win_len | input | 8 | Window length in samples |
| irq_en | input | 1 | Interrupt flag enable |
| trip_clear | input | 1 | Clears trip and interrupt flag, restarts the window |
| trip | output | 1 | Sticky overload trip |
| irq_flag | output | 1 | Masked limit-fault interrupt flag |
| hist_data | output | 128 | Eight-deep sample history, slot 0 newest |

## Verification
The assertions assume that the limits, `need_cnt` and `win_len` stay constant while a window is in progress. They also assume that `lim_lo` does not exceed `lim_hi`. The stimulus changes these settings only between tests and follows every change with a `trip_clear`, so each test starts from the first window position. Every sample sequence is built so that the window boundary case under test falls at a known position: overloads at the end of one window followed by overloads at the start of the next, samples exactly on a limit, and clears that coincide with a sample.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    typedef enum logic {
        ST_ARMED   = 1'b0,
        ST_TRIPPED = 1'b1
    } trip_st_t;

    // Strict out-of-band test on zero-extended operands
    function automatic logic beyond_band(input logic [31:0] smp,
                                         input logic [31:0] hi,
                                         input logic [31:0] lo);
        return (smp > hi) || (smp < lo);
    endfunction

endpackage

// File: rtl/ovl_window.sv
module ovl_window #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             over,
    input  logic             restart,
    input  logic [CNT_W-1:0] need,
    input  logic [CNT_W-1:0] win,
    output logic             hit
);
    typedef struct packed {
        logic [CNT_W-1:0] pos;
        logic [CNT_W-1:0] cnt;
    } win_state_t;

    win_state_t st_q, st_d;
    logic [CNT_W-1:0] base;
    logic             last;

    always_comb begin
        base = (st_q.pos == '0) ? '0 : st_q.cnt;
        last = (win == '0) || (st_q.pos >= win - CNT_W'(1));
        st_d = st_q;
        hit  = 1'b0;
        if (take) begin
            st_d.cnt = base + CNT_W'(over);
            st_d.pos = last ? '0 : st_q.pos + CNT_W'(1);
            hit      = over && (st_d.cnt >= need);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) st_q <= '0;
        else                st_q <= st_d;
    end

    // R3: a window never holds more overloads than samples taken in it
    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        (st_q.pos != '0) |-> (st_q.cnt <= st_q.pos));

    // R8: with no sample taken and no restart, window state holds
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!take && !restart) |=> $stable(st_q));

endmodule

// File: rtl/ovl_history.sv
module ovl_history #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    shift_en,
    input  logic                    freeze,
    input  logic [DATA_W-1:0]       din,
    output logic [DEPTH*DATA_W-1:0] hist
);
    logic [DATA_W-1:0] slot_q [DEPTH];

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)                      slot_q[k] <= '0;
                else if (shift_en && !freeze) slot_q[k] <= (k == 0) ? din : slot_q[(k == 0) ? 0 : k-1];
            end
            assign hist[k*DATA_W +: DATA_W] = slot_q[k];
        end
    endgenerate

    // R6: history does not move while a trip is pending
    a_r6_hist_frozen: assert property (@(posedge clk) disable iff (rst)
        freeze |=> $stable(hist));

endmodule

// File: rtl/ovl_trip_detector.sv
module ovl_trip_detector
    import ovl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8,
    parameter int HIST_N = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_valid,
    input  logic [DATA_W-1:0]        smp_data,
    input  logic [DATA_W-1:0]        lim_hi,
    input  logic [DATA_W-1:0]        lim_lo,
    input  logic [CNT_W-1:0]         need_cnt,
    input  logic [CNT_W-1:0]         win_len,
    input  logic                     irq_en,
    input  logic                     trip_clear,
    output logic                     trip,
    output logic                     irq_flag,
    output logic [HIST_N*DATA_W-1:0] hist_data
);
    trip_st_t st_q;
    logic     irq_q;
    logic     take, over, hit;

    assign take = smp_valid && (st_q == ST_ARMED) && !trip_clear;
    assign over = beyond_band(32'(smp_data), 32'(lim_hi), 32'(lim_lo));

    ovl_window #(.CNT_W(CNT_W)) u_window (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .over    (over),
        .restart (trip_clear),
        .need    (need_cnt),
        .win     (win_len),
        .hit     (hit)
    );

    ovl_history #(.DATA_W(DATA_W), .DEPTH(HIST_N)) u_history (
        .clk      (clk),
        .rst      (rst),
        .shift_en (take),
        .freeze   (trip),
        .din      (smp_data),
        .hist     (hist_data)
    );

    always_ff @(posedge clk) begin
        if (rst || trip_clear) begin
            st_q  <= ST_ARMED;
            irq_q <= 1'b0;
        end else if (hit) begin
            st_q  <= ST_TRIPPED;
            irq_q <= irq_q | irq_en;
        end
    end

    assign trip     = (st_q == ST_TRIPPED);
    assign irq_flag = irq_q;

    // R4: trip is sticky until cleared
    a_r4_trip_sticky: assert property (@(posedge clk) disable iff (rst)
        (trip && !trip_clear) |=> trip);

    // R5: clear drops both outputs
    a_r5_clear_drops: assert property (@(posedge clk) disable iff (rst)
        trip_clear |=> (!trip && !irq_flag));

    // R7: the interrupt flag never stands without a trip
    a_r7_irq_needs_trip: assert property (@(posedge clk) disable iff (rst)
        irq_flag |-> trip);

    // R2: a rising trip follows a valid out-of-band sample
    a_r2_trip_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(trip) |-> $past(smp_valid && over));

endmodule

// File: tb/test_ovl_trip_detector.sv
module test_ovl_trip_detector;
    localparam int W = 16;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0;
    logic [W-1:0] smp_data = '0;
    logic [W-1:0] lim_hi = '1;
    logic [W-1:0] lim_lo = '0;
    logic [7:0] need_cnt = 8'd4;
    logic [7:0] win_len = 8'd4;
    logic irq_en = 1'b1;
    logic trip_clear = 1'b0;
    logic trip, irq_flag;
    logic [N*W-1:0] hist_data;

    always #2 clk = ~clk;

    ovl_trip_detector i_ovl_trip_detector (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .need_cnt(need_cnt), .win_len(win_len),
        .irq_en(irq_en), .trip_clear(trip_clear), .trip(trip), .irq_flag(irq_flag),
        .hist_data(hist_data)
    );

    typedef struct {
        logic           trip;
        logic           irq;
        logic [N*W-1:0] hist;
        string          tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference state, built from the requirements
    logic           m_trip = 0, m_irq = 0;
    int             m_pos = 0, m_cnt = 0;
    logic [N*W-1:0] m_hist = '0;

    task automatic chk(input logic [N*W-1:0] act, input logic [N*W-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model(input logic v, input logic [W-1:0] d, input logic clr);
        if (clr) begin
            m_trip = 0; m_irq = 0; m_pos = 0; m_cnt = 0;
        end else if (v && !m_trip) begin
            logic ovr;
            int   nc;
            ovr = (d > lim_hi) || (d < lim_lo);
            nc  = ((m_pos == 0) ? 0 : m_cnt) + int'(ovr);
            m_hist = {m_hist[(N-1)*W-1:0], d};
            m_pos  = (win_len == 0 || m_pos >= int'(win_len) - 1) ? 0 : m_pos + 1;
            m_cnt  = nc;
            if (ovr && nc >= int'(need_cnt)) begin
                m_trip = 1;
                m_irq  = irq_en;
            end
        end
    endtask

    task automatic send(input logic v, input logic [W-1:0] d, input logic clr, input string tag);
        item_t it;
        @(negedge clk);
        smp_valid = v; smp_data = d; trip_clear = clr;
        @(posedge clk);
        #1;
        model(v, d, clr);
        it.trip = m_trip; it.irq = m_irq; it.hist = m_hist; it.tag = tag;
        q.push_back(it);
        smp_valid = 0; trip_clear = 0;
    endtask

    // monitor: compare outputs against queued expectations
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            chk({127'd0, trip}, {127'd0, it.trip}, {it.tag, " trip"});
            chk({127'd0, irq_flag}, {127'd0, it.irq}, {it.tag, " irq"});
            chk(hist_data, it.hist, {it.tag, " hist"});
        end
    end

    task automatic drain;
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk);
        // R1 reset state
        chk({127'd0, trip}, 128'd0, "R1 trip after reset");
        chk({127'd0, irq_flag}, 128'd0, "R1 irq after reset");
        chk(hist_data, '0, "R1 hist after reset");

        // R9 full range: extreme values never trip
        lim_hi = '1; lim_lo = '0; need_cnt = 1; win_len = 1;
        send(1, 16'h0000, 0, "R9 zero");
        send(1, 16'hFFFF, 0, "R9 max");
        for (int i = 0; i < 10; i++) send(1, W'(i * 6553), 0, "R9 sweep");
        drain;
        chk({127'd0, trip}, 128'd0, "R9 no trip at full range");

        // R3 window of 4, need 4: 3 overloads then in-band -> no trip
        lim_hi = 16'd1000; lim_lo = 16'd100; need_cnt = 4; win_len = 4; irq_en = 1;
        send(0, 0, 1, "R5 restart");
        send(1, 16'd2000, 0, "R3 w0 over");
        send(1, 16'd50,   0, "R3 w0 under");
        send(1, 16'd3000, 0, "R3 w0 over");
        send(1, 16'd500,  0, "R3 w0 inband");
        send(1, 16'd1001, 0, "R3 w1 over");
        send(1, 16'd99,   0, "R3 w1 under");
        send(1, 16'd4000, 0, "R3 w1 over");
        drain;
        chk({127'd0, trip}, 128'd0, "R3 three overloads do not trip");
        send(1, 16'd5000, 0, "R3 w1 fourth over trips");
        drain;
        chk({127'd0, trip}, 128'd1, "R3 trip on fourth overload");
        chk({127'd0, irq_flag}, 128'd1, "R7 irq with enable");
        chk({112'd0, hist_data[15:0]}, 128'd5000, "R6 tripping sample newest");

        // R4/R6 further samples ignored
        send(1, 16'd42, 0, "R4 ignored while tripped");
        send(1, 16'd7,  0, "R6 frozen history");
        // R5 clear with simultaneous sample ignored
        send(1, 16'd9999, 1, "R5 clear with sample");
        drain;
        chk({127'd0, trip}, 128'd0, "R5 trip cleared");
        chk({112'd0, hist_data[15:0]}, 128'd5000, "R5 sample during clear ignored");

        // R3 count restarts across window boundary; win 5 need 2
        need_cnt = 2; win_len = 5;
        send(0, 0, 1, "R5 restart");
        send(1, 16'd500, 0, "R3 p0");
        send(1, 16'd500, 0, "R3 p1");
        send(1, 16'd500, 0, "R3 p2");
        send(1, 16'd500, 0, "R3 p3");
        send(1, 16'd2000, 0, "R3 p4 over");
        send(1, 16'd2000, 0, "R3 next p0 over no carry");
        drain;
        chk({127'd0, trip}, 128'd0, "R3 no carry across windows");
        send(1, 16'd2000, 0, "R3 next p1 over trips");
        drain;
        chk({127'd0, trip}, 128'd1, "R3 trip within window");

        // R2 equal to limits is not an overload; R8 invalid ignored
        need_cnt = 1; win_len = 3;
        send(0, 0, 1, "R5 restart");
        send(1, 16'd1000, 0, "R2 equal hi");
        send(1, 16'd100,  0, "R2 equal lo");
        send(0, 16'd9000, 0, "R8 invalid over");
        send(0, 16'd1,    0, "R8 invalid under");
        drain;
        chk({127'd0, trip}, 128'd0, "R2 R8 no trip");
        chk({96'd0, hist_data[31:0]}, {96'd0, 16'd1000, 16'd100}, "R8 history untouched");

        // R7 masked interrupt; need 0 and win 0 act as 1
        irq_en = 0; need_cnt = 0; win_len = 0;
        send(1, 16'd1001, 0, "R7 masked trip");
        drain;
        chk({127'd0, trip}, 128'd1, "R3 need zero trips on single overload");
        chk({127'd0, irq_flag}, 128'd0, "R7 irq masked");
        irq_en = 1;
        send(1, 16'd3, 0, "R7 enable after trip no irq");
        send(0, 0, 1, "R5 final clear");
        drain;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule